// File: doc/BRIEF.md
# Circular-Pipeline Route Lookup Engine

This block turns a 32-bit IPv4 destination key into a route result by walking a table of up to three levels held in one on-chip synchronous memory. An accepted key makes its first memory read from its upper half. Its lower half waits in a one-entry loop slot until that read returns. If the returned entry is a pointer, the engine computes the next address from the entry and the next byte of the waiting remainder. It issues that read and writes the shifted remainder back into the slot in the same cycle. If the entry is a leaf, the result goes to a small output queue and the slot is freed.

Deciding between leaving and looping separately lets a new key enter in the same cycle a finished one leaves. A looping key always has priority over a new key for the memory port and the slot. A write port loads the table while no lookup is in flight.

A table entry with bit 31 set is a leaf, and its bits [30:0] are the route result. With bit 31 clear, bits [30:0] are the base address of the next level.

Top module: `route_walk_engine`

## Requirements
- R1: The first read uses the low TBL_AW bits of key bits [31:16] as the address. An entry with bit 31 set ends the lookup after one access, and out_route carries its bits [30:0].
- R2: A pointer entry makes the second read at address (entry[30:0] + key[15:8] sign-extended), truncated to TBL_AW bits. A negative offset lands below the base.
- R3: The third read adds key[7:0] sign-extended to the base in the second entry. The entry it returns is emitted as the result even when its bit 31 is clear.
- R4: With the output queue empty and out_ready high, out_valid rises N clock cycles after the edge that accepts the key, where N is the number of memory accesses (1 to 3).
- R5: In a cycle where a leaf result leaves the slot, in_ready is high, so single-access lookups can be accepted on consecutive cycles.
- R6: In every cycle where a pointer entry sends a lookup around the loop again, in_ready is low.
- R7: Results leave in the order their keys were accepted. The output queue holds OUT_DEPTH results. While it is full, a finished lookup waits in the slot and blocks new keys. out_route stays stable while out_valid is high and out_ready is low.
- R8: tbl_wr_ready is high only when no lookup is in flight. While tbl_wr_en is high, in_ready is low, and a write and an accepted key never share a cycle.
- R9: A synchronous active-high reset empties the slot and the output queue. After it, out_valid is low and in_ready and tbl_wr_ready are high, even if a lookup was in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Key offered |
| in_ready | output | 1 | Key accepted this cycle when in_valid is high |
| in_key | input | 32 | Destination address to resolve |
| tbl_wr_en | input | 1 | Table write request |
| tbl_wr_ready | output | 1 | Table write accepted (no lookup in flight) |
| tbl_wr_addr | input | TBL_AW | Table word address |
| tbl_wr_data | input | 32 | Table word |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_route | output | 31 | Route result of the oldest finished lookup |

## Verification
Keys are chosen to end after one, two and three accesses. This separates the address used at each level, the sign of the byte offset, the truncation of the first address and the forced leaf at the third level, and the result latency pins down how many memory reads took place. Back-to-back single-access keys show whether an exit frees the slot for a new key in the same cycle. A three-level key held against a waiting second key shows whether the loop wins the port. Holding out_ready low over three lookups exercises the queue limit, ordering and the hold of the output. Table writes during and between lookups, and a reset in mid-walk, cover the exclusion rule and the clearing of state.

// File: rtl/rwe_pkg.sv
package rwe_pkg;

    localparam int KEY_W    = 32;
    localparam int ENT_W    = 32;
    localparam int LEAF_POS = 31;
    localparam int RES_W    = 31;
    localparam int REM_W    = 16;
    localparam int STEP_W   = 8;
    localparam int MAX_ACC  = 3;
    localparam int LVL_W    = 2;

    // Contents of the loop slot: unconsumed key bits and accesses made so far
    typedef struct packed {
        logic [REM_W-1:0] rem;
        logic [LVL_W-1:0] lvl;
    } loop_ent_t;

    // Next-level address: base plus sign-extended top byte of the remainder
    function automatic logic [ENT_W-1:0] step_addr(input logic [ENT_W-1:0] ent,
                                                   input logic [REM_W-1:0] rem);
        logic [ENT_W-1:0] base;
        logic [ENT_W-1:0] ofs;
        base = {1'b0, ent[RES_W-1:0]};
        ofs  = {{(ENT_W-STEP_W){rem[REM_W-1]}}, rem[REM_W-1 -: STEP_W]};
        return base + ofs;
    endfunction

    // A walk ends on a marked leaf or once the deepest level has been read
    function automatic logic ends_walk(input logic [ENT_W-1:0] ent,
                                       input logic [LVL_W-1:0] lvl);
        return ent[LEAF_POS] || (lvl == LVL_W'(MAX_ACC));
    endfunction

    function automatic loop_ent_t advance(input loop_ent_t e);
        loop_ent_t n;
        n.rem = e.rem << STEP_W;
        n.lvl = e.lvl + 1'b1;
        return n;
    endfunction

endpackage

// File: rtl/rwe_table_mem.sv
module rwe_table_mem #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    // Single port: one write or one read per cycle; read data holds until the next read
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                rdata <= mem[addr];
            end
        end
    end
endmodule

// File: rtl/rwe_loop_slot.sv
module rwe_loop_slot
    import rwe_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rd_en,
    input  logic      wr_en,
    input  loop_ent_t wr_data,
    output logic      full,
    output logic      wr_ready,
    output loop_ent_t rd_data
);
    loop_ent_t held;
    logic      full_q;

    // The read counts as taking place before the write in the same cycle
    assign wr_ready = !full_q || rd_en;
    assign full     = full_q;
    assign rd_data  = held;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
        end else if (wr_en) begin
            full_q <= 1'b1;
        end else if (rd_en) begin
            full_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            held <= wr_data;
        end
    end
endmodule

// File: rtl/rwe_out_queue.sv
module rwe_out_queue #(
    parameter int DW    = 31,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          full,
    output logic          nonempty,
    output logic [DW-1:0] head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full     = (count == CW'(DEPTH));
    assign nonempty = (count != '0);
    assign head     = store[rd_ptr];
    assign do_push  = push && !full;
    assign do_pop   = pop && nonempty;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop) begin
                count <= count + 1'b1;
            end else if (do_pop && !do_push) begin
                count <= count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= push_data;
        end
    end
endmodule

// File: rtl/route_walk_engine.sv
module route_walk_engine
    import rwe_pkg::*;
#(
    parameter int TBL_AW    = 10,
    parameter int OUT_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [KEY_W-1:0]  in_key,
    input  logic              tbl_wr_en,
    output logic              tbl_wr_ready,
    input  logic [TBL_AW-1:0] tbl_wr_addr,
    input  logic [ENT_W-1:0]  tbl_wr_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [RES_W-1:0]  out_route
);
    localparam int HI_LSB = KEY_W - REM_W;

    // Memory port
    logic              mem_en, mem_we;
    logic [TBL_AW-1:0] mem_addr;
    logic [ENT_W-1:0]  mem_rdata;

    // Loop slot
    loop_ent_t slot_q, slot_d;
    logic      slot_full, slot_wr_ready, slot_rd, slot_wr;

    // Output queue
    logic oq_full;

    // Control
    logic             resp_v;
    logic             finish, exit_fire, recirc_fire, in_fire, wr_fire, rd_issue;
    logic [ENT_W-1:0] next_addr;

    // Split decision: the returned entry either leaves or loops
    assign finish      = ends_walk(mem_rdata, slot_q.lvl);
    assign exit_fire   = resp_v && finish && !oq_full;
    assign recirc_fire = resp_v && !finish;
    assign slot_rd     = exit_fire || recirc_fire;
    assign next_addr   = step_addr(mem_rdata, slot_q.rem);

    // Table writes only while nothing circulates; they take the port
    assign tbl_wr_ready = !slot_full;
    assign wr_fire      = tbl_wr_en && tbl_wr_ready;

    // The loop beats new keys; a pending table write also holds them off
    assign in_ready = slot_wr_ready && !recirc_fire && !tbl_wr_en;
    assign in_fire  = in_valid && in_ready;

    assign rd_issue = in_fire || recirc_fire;
    assign mem_en   = wr_fire || rd_issue;
    assign mem_we   = wr_fire;

    always_comb begin
        mem_addr = in_key[HI_LSB +: TBL_AW];
        if (wr_fire) begin
            mem_addr = tbl_wr_addr;
        end else if (recirc_fire) begin
            mem_addr = next_addr[TBL_AW-1:0];
        end
    end

    always_comb begin
        slot_wr = rd_issue;
        slot_d  = advance(slot_q);
        if (!recirc_fire) begin
            slot_d.rem = in_key[REM_W-1:0];
            slot_d.lvl = LVL_W'(1);
        end
    end

    // A response stays available until the walk leaves or issues its next read
    always_ff @(posedge clk) begin
        if (rst) begin
            resp_v <= 1'b0;
        end else if (rd_issue) begin
            resp_v <= 1'b1;
        end else if (exit_fire) begin
            resp_v <= 1'b0;
        end
    end

    rwe_table_mem #(
        .AW(TBL_AW),
        .DW(ENT_W)
    ) u_mem (
        .clk  (clk),
        .en   (mem_en),
        .we   (mem_we),
        .addr (mem_addr),
        .wdata(tbl_wr_data),
        .rdata(mem_rdata)
    );

    rwe_loop_slot u_slot (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (slot_rd),
        .wr_en   (slot_wr),
        .wr_data (slot_d),
        .full    (slot_full),
        .wr_ready(slot_wr_ready),
        .rd_data (slot_q)
    );

    rwe_out_queue #(
        .DW   (RES_W),
        .DEPTH(OUT_DEPTH)
    ) u_oq (
        .clk      (clk),
        .rst      (rst),
        .push     (exit_fire),
        .push_data(mem_rdata[RES_W-1:0]),
        .pop      (out_ready),
        .full     (oq_full),
        .nonempty (out_valid),
        .head     (out_route)
    );

    initial begin
        if (TBL_AW > REM_W || TBL_AW < 1) $error("TBL_AW must lie in 1..16");
        if (OUT_DEPTH < 1) $error("OUT_DEPTH must be at least 1");
    end
endmodule

// File: rtl/rwe_checker.sv
module rwe_checker
    import rwe_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             tbl_wr_en,
    input logic             tbl_wr_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [RES_W-1:0] out_route,
    input logic             slot_full,
    input logic             resp_v,
    input logic [LVL_W-1:0] slot_lvl
);
    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_route)));

    // R8
    wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (tbl_wr_en && tbl_wr_ready) |-> !(in_valid && in_ready));

    // R8
    wr_busy_chk: assert property (@(posedge clk) disable iff (rst)
        resp_v |-> !tbl_wr_ready);

    // R5
    accept_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> slot_full);

    // R3
    level_range_chk: assert property (@(posedge clk) disable iff (rst)
        slot_full |-> (slot_lvl != '0));
endmodule

bind route_walk_engine rwe_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .tbl_wr_en   (tbl_wr_en),
    .tbl_wr_ready(tbl_wr_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_route   (out_route),
    .slot_full   (slot_full),
    .resp_v      (resp_v),
    .slot_lvl    (slot_q.lvl)
);

// File: tb/route_walk_engine_tb_top.sv
module route_walk_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [31:0]   in_key = '0;
    logic          tbl_wr_en = 1'b0;
    logic          tbl_wr_ready;
    logic [AW-1:0] tbl_wr_addr = '0;
    logic [31:0]   tbl_wr_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [30:0]   out_route;

    int nchk = 0;
    int nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    route_walk_engine #(.TBL_AW(AW), .OUT_DEPTH(2)) dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_key(in_key),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_ready(tbl_wr_ready),
        .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_route(out_route)
    );

    typedef struct packed {
        logic [31:0] key;
        logic [30:0] res;
        logic [3:0]  acc;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'h0001_1234, 31'h111, 4'd1},   // R1 leaf at level one
        '{32'h0401_0000, 31'h111, 4'd1},   // R1 upper key bits truncated
        '{32'h0002_0599, 31'h222, 4'd2},   // R2 positive offset
        '{32'h0002_FE01, 31'h333, 4'd2},   // R2 negative offset
        '{32'h0003_0407, 31'h444, 4'd3},   // R3 third entry unmarked, still a result
        '{32'h0003_0405, 31'h555, 4'd3}    // R3 third entry marked leaf
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tbl_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_addr = a; tbl_wr_data = d;
        @(posedge clk);
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    // Offers one key, returns the result and the cycles from accept to out_valid
    task automatic lookup(input logic [31:0] k, output logic [30:0] r, output int n);
        @(negedge clk);
        in_valid = 1'b1; in_key = k;
        #1;
        for (int g = 0; g < 20 && !in_ready; g++) begin
            @(negedge clk); #1;
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        n = 0;
        while (!out_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        r = out_route;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [30:0] r;
        int n;

        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R9 out_valid after reset", 32'(out_valid), 32'd0);
        chk("R9 in_ready after reset", 32'(in_ready), 32'd1);
        chk("R9 tbl_wr_ready after reset", 32'(tbl_wr_ready), 32'd1);

        tbl_write(10'h001, 32'h8000_0111);
        tbl_write(10'h002, 32'h0000_0100);
        tbl_write(10'h105, 32'h8000_0222);
        tbl_write(10'h0FE, 32'h8000_0333);
        tbl_write(10'h003, 32'h0000_0200);
        tbl_write(10'h204, 32'h0000_0300);
        tbl_write(10'h307, 32'h0000_0444);
        tbl_write(10'h305, 32'h8000_0555);
        tbl_write(10'h004, 32'h8000_0666);
        tbl_write(10'h005, 32'h8000_0777);

        // Vector table: R1, R2, R3 results and R4 latency
        foreach (VECS[i]) begin
            lookup(VECS[i].key, r, n);
            chk($sformatf("R1/R2/R3 result key %h", VECS[i].key), 32'(r), 32'(VECS[i].res));
            chk($sformatf("R4 latency key %h", VECS[i].key), 32'(n), 32'(VECS[i].acc));
            repeat (2) @(negedge clk);
        end

        // R5: exit and entry in one cycle
        @(negedge clk);
        in_valid = 1'b1; in_key = 32'h0001_0000;
        @(posedge clk);
        @(negedge clk);
        in_key = 32'h0004_0000;
        #1;
        chk("R5 in_ready during exit", 32'(in_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R5 first result", 32'(out_route), 32'h111);
        @(negedge clk);
        chk("R5 second result valid", 32'(out_valid), 32'd1);
        chk("R5 second result", 32'(out_route), 32'h666);
        repeat (3) @(negedge clk);

        // R6: loop wins over a waiting key
        in_valid = 1'b1; in_key = 32'h0003_0407;
        @(posedge clk);
        @(negedge clk);
        in_key = 32'h0001_0000;
        #1;
        chk("R6 in_ready while looping (2nd access)", 32'(in_ready), 32'd0);
        @(negedge clk); #1;
        chk("R6 in_ready while looping (3rd access)", 32'(in_ready), 32'd0);
        @(negedge clk); #1;
        chk("R6 in_ready once walk exits", 32'(in_ready), 32'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6 looped result first", 32'(out_route), 32'h444);
        @(negedge clk);
        chk("R6 waiting key result", 32'(out_route), 32'h111);
        repeat (3) @(negedge clk);

        // R7: back-pressure, queue limit, order and hold
        out_ready = 1'b0;
        in_valid = 1'b1; in_key = 32'h0001_0000;
        @(posedge clk); @(negedge clk);
        in_key = 32'h0004_0000;
        @(posedge clk); @(negedge clk);
        in_key = 32'h0005_0000;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk("R7 in_ready low with queue full", 32'(in_ready), 32'd0);
        chk("R7 head while stalled", 32'(out_route), 32'h111);
        repeat (3) @(negedge clk);
        chk("R7 head stable", 32'(out_route), 32'h111);
        out_ready = 1'b1;
        @(negedge clk);
        chk("R7 second in order", 32'(out_route), 32'h666);
        @(negedge clk);
        chk("R7 third in order", 32'(out_route), 32'h777);
        @(negedge clk);
        chk("R7 queue drained", 32'(out_valid), 32'd0);

        // R8: writes blocked in flight, and writes hold off keys
        in_valid = 1'b1; in_key = 32'h0002_0599;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk("R8 tbl_wr_ready during lookup", 32'(tbl_wr_ready), 32'd0);
        repeat (4) @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_addr = 10'h004; tbl_wr_data = 32'h8000_0666;
        in_valid = 1'b1; in_key = 32'h0004_0000;
        #1;
        chk("R8 tbl_wr_ready idle", 32'(tbl_wr_ready), 32'd1);
        chk("R8 in_ready during write", 32'(in_ready), 32'd0);
        @(posedge clk); @(negedge clk);
        tbl_wr_en = 1'b0;
        in_valid = 1'b0;
        lookup(32'h0004_0000, r, n);
        chk("R8 table intact after write", 32'(r), 32'h666);
        repeat (3) @(negedge clk);

        // R9: reset in mid-walk
        in_valid = 1'b1; in_key = 32'h0003_0407;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R9 out_valid after mid reset", 32'(out_valid), 32'd0);
        chk("R9 in_ready after mid reset", 32'(in_ready), 32'd1);
        chk("R9 tbl_wr_ready after mid reset", 32'(tbl_wr_ready), 32'd1);
        repeat (4) @(negedge clk);
        chk("R9 no stale result", 32'(out_valid), 32'd0);

        summary();
    end
endmodule